// File: doc/BRIEF.md
# Power Button Event Logic

This block turns an active-low power button into a sticky event for the power-management logic. The raw button line passes through a synchronizer. A press latches a status bit that software clears by writing a one. An enable bit chooses whether the latched event reaches the processor. While the system runs (S0) the event becomes a system control interrupt or a system management interrupt, depending on the interrupt-routing select input. In a sleep state (S1 to S5) it becomes a wake request.

A press held past a hold threshold is treated as an override. Hardware drops the press status, latches a separate override status, leaves the button armed as the wake source, and sends a one-cycle request to the power sequencer to enter soft-off (S5). The sequencer disables every other wake source. The threshold is given as a clock rate and a hold time in milliseconds, so one build can run on any clock. A warm reset leaves both status bits unchanged; only the power-on reset clears them.

Top module: `pwrbtn_ctl`

## Requirements
- R1: After power-on reset, btn_sts, ovr_sts, btn_en, sci_req, smi_req, wake_req and go_s5 are all 0.
- R2: A falling edge on btn_n sets btn_sts, whatever btn_en holds. btn_sts reads 1 from the third rising clock edge after the edge that first samples btn_n low.
- R3: If btn_sts is cleared while btn_n stays low, btn_sts stays 0. It sets again only after btn_n goes high and then low once more.
- R4: A write with wr_addr=0 clears btn_sts when wr_data bit 0 is 1 and clears ovr_sts when wr_data bit 1 is 1. A 0 in either bit leaves that status unchanged. A write with wr_addr=1 loads btn_en from wr_data bit 0. A press edge in the same cycle as a clear wins.
- R5: With pstate=0 (S0), btn_en=1 and btn_sts=1, sci_req is 1 when sci_en=1 and smi_req is 1 when sci_en=0. wake_req stays 0. At most one of the three requests is high at any time.
- R6: With pstate from 1 to 5 (S1 to S5), btn_en=1 and btn_sts=1, wake_req is 1 and sci_req and smi_req are 0. pstate values 6 and 7 raise no request.
- R7: When btn_n has been low for HOLD_CYCLES = CLK_HZ*HOLD_MS/1000 cycles after synchronization, go_s5 pulses. The pulse is high during the cycle after rising edge 3+HOLD_CYCLES, counted from the edge that first samples btn_n low. On that same edge btn_sts clears, ovr_sts sets and btn_en sets.
- R8: go_s5 is high for a single cycle and pulses once per continuous hold. Releasing the button before the threshold restarts the hold count, and a new hold after a release can pulse again.
- R9: A warm_rst pulse clears btn_en and leaves btn_sts and ovr_sts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset pulse from the reset-control write |
| btn_n | input | 1 | Raw power button, low while pressed |
| pstate | input | 3 | Current power state: 0 = S0, 1..5 = S1..S5 |
| sci_en | input | 1 | 1 routes run-time events to sci_req, 0 routes them to smi_req |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = status register (write one to clear), 1 = enable register |
| wr_data | input | 2 | Write data: bit 0 press status or enable, bit 1 override status |
| btn_sts | output | 1 | Latched press status |
| ovr_sts | output | 1 | Latched hold-override status |
| btn_en | output | 1 | Press event enable |
| sci_req | output | 1 | System control interrupt request (S0) |
| smi_req | output | 1 | System management interrupt request (S0) |
| wake_req | output | 1 | Wake request (S1 to S5) |
| go_s5 | output | 1 | One-cycle request to enter soft-off |

## Verification
The assertions check on every cycle that the request outputs never overlap, that S0 never yields a wake request, and that go_s5 lasts one cycle. They also check that btn_sts rises only after a detected press edge, that go_s5 coincides with the override status, that a clear write takes effect, and that a warm reset drops the enable. Only the bench scenarios can show the exact cycle the override fires, that the hold count restarts after a short press, and that a clear during a held press is not undone. The same applies to the routing across each power state and to the status bits surviving a warm reset.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;

  localparam logic ADDR_STS = 1'b0;
  localparam logic ADDR_EN  = 1'b1;
  localparam int   BIT_BTN  = 0;
  localparam int   BIT_OVR  = 1;

  typedef enum logic [2:0] {
    PS_S0 = 3'd0,
    PS_S1 = 3'd1,
    PS_S2 = 3'd2,
    PS_S3 = 3'd3,
    PS_S4 = 3'd4,
    PS_S5 = 3'd5
  } pstate_e;

  // Cycles for the override hold, never below one.
  function automatic int unsigned hold_limit(input int unsigned hz, input int unsigned ms);
    longint unsigned t;
    t = (longint'(hz) * longint'(ms)) / 64'd1000;
    return (t < 64'd1) ? 1 : int'(t);
  endfunction

  function automatic logic is_run(input logic [2:0] ps);
    return ps == PS_S0;
  endfunction

  function automatic logic is_sleep(input logic [2:0] ps);
    return (ps >= PS_S1) && (ps <= PS_S5);
  endfunction

endpackage

// File: rtl/pwrbtn_sync.sv
module pwrbtn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic btn_n,
  output logic pressed,
  output logic press_edge
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          pressed_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) chain <= '1;
        else        chain <= btn_n;
    end else begin : g_many
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) chain <= '1;
        else        chain <= {chain[LAST-1:0], btn_n};
    end
  endgenerate

  assign pressed = ~chain[LAST];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) pressed_d <= 1'b0;
    else        pressed_d <= pressed;

  assign press_edge = pressed & ~pressed_d;
endmodule

// File: rtl/pwrbtn_hold.sv
module pwrbtn_hold #(
  parameter int unsigned HOLD_CYCLES = 40
) (
  input  logic clk,
  input  logic por_n,
  input  logic pressed,
  output logic hold_expire
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt;
  logic          fired;

  assign hold_expire = pressed && (cnt == LIMIT) && !fired;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!pressed) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      if (cnt != LIMIT) cnt <= cnt + 1'b1;
      if (hold_expire)  fired <= 1'b1;
    end
  end
endmodule

// File: rtl/pwrbtn_route.sv
module pwrbtn_route
  import pwrbtn_pkg::*;
(
  input  logic [2:0] pstate,
  input  logic       sci_en,
  input  logic       btn_en,
  input  logic       btn_sts,
  output logic       sci_req,
  output logic       smi_req,
  output logic       wake_req
);
  logic event_live;

  assign event_live = btn_en & btn_sts;

  always_comb begin
    sci_req  = 1'b0;
    smi_req  = 1'b0;
    wake_req = 1'b0;
    if (event_live) begin
      if (is_run(pstate)) begin
        if (sci_en) sci_req = 1'b1;
        else        smi_req = 1'b1;
      end else if (is_sleep(pstate)) begin
        wake_req = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwrbtn_ctl.sv
module pwrbtn_ctl
  import pwrbtn_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 32768,
  parameter int unsigned HOLD_MS     = 4000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       warm_rst,
  input  logic       btn_n,
  input  logic [2:0] pstate,
  input  logic       sci_en,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [1:0] wr_data,
  output logic       btn_sts,
  output logic       ovr_sts,
  output logic       btn_en,
  output logic       sci_req,
  output logic       smi_req,
  output logic       wake_req,
  output logic       go_s5
);
  localparam int unsigned HOLD_CYCLES = hold_limit(CLK_HZ, HOLD_MS);

  logic pressed;
  logic press_edge;
  logic hold_expire;
  logic sts_clr;
  logic ovr_clr;
  logic en_wr;

  pwrbtn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .por_n      (por_n),
    .btn_n      (btn_n),
    .pressed    (pressed),
    .press_edge (press_edge)
  );

  pwrbtn_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk         (clk),
    .por_n       (por_n),
    .pressed     (pressed),
    .hold_expire (hold_expire)
  );

  assign sts_clr = wr_en && (wr_addr == ADDR_STS) && wr_data[BIT_BTN];
  assign ovr_clr = wr_en && (wr_addr == ADDR_STS) && wr_data[BIT_OVR];
  assign en_wr   = wr_en && (wr_addr == ADDR_EN);

  // Status bits: power-on reset only.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      btn_sts <= 1'b0;
      ovr_sts <= 1'b0;
      go_s5   <= 1'b0;
    end else begin
      go_s5 <= hold_expire;
      if (hold_expire)     btn_sts <= 1'b0;
      else if (press_edge) btn_sts <= 1'b1;
      else if (sts_clr)    btn_sts <= 1'b0;
      if (hold_expire)     ovr_sts <= 1'b1;
      else if (ovr_clr)    ovr_sts <= 1'b0;
    end
  end

  // Enable: also dropped by warm reset.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           btn_en <= 1'b0;
    else if (warm_rst)    btn_en <= 1'b0;
    else if (hold_expire) btn_en <= 1'b1;
    else if (en_wr)       btn_en <= wr_data[BIT_BTN];
  end

  pwrbtn_route u_route (
    .pstate   (pstate),
    .sci_en   (sci_en),
    .btn_en   (btn_en),
    .btn_sts  (btn_sts),
    .sci_req  (sci_req),
    .smi_req  (smi_req),
    .wake_req (wake_req)
  );
endmodule

// File: rtl/pwrbtn_chk.sv
module pwrbtn_chk (
  input logic       clk,
  input logic       por_n,
  input logic       warm_rst,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [1:0] wr_data,
  input logic [2:0] pstate,
  input logic       press_edge,
  input logic       btn_sts,
  input logic       ovr_sts,
  input logic       btn_en,
  input logic       sci_req,
  input logic       smi_req,
  input logic       wake_req,
  input logic       go_s5
);
  AST_STS_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(btn_sts) |-> $past(press_edge)); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !wr_addr && wr_data[0] && !press_edge) |=> !btn_sts); // R4

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({sci_req, smi_req, wake_req})); // R5

  AST_RUN_NO_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    (pstate == 3'd0) |-> !wake_req); // R6

  AST_OVR_WITH_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    go_s5 |-> (ovr_sts && !btn_sts && btn_en)); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    go_s5 |=> !go_s5); // R8

  AST_WARM_DROPS_EN: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |=> !btn_en); // R9
endmodule

bind pwrbtn_ctl pwrbtn_chk u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .warm_rst   (warm_rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .pstate     (pstate),
  .press_edge (press_edge),
  .btn_sts    (btn_sts),
  .ovr_sts    (ovr_sts),
  .btn_en     (btn_en),
  .sci_req    (sci_req),
  .smi_req    (smi_req),
  .wake_req   (wake_req),
  .go_s5      (go_s5)
);

// File: tb/pwrbtn_ctl_tb.sv
module pwrbtn_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 10000;
  localparam int MS = 4;
  localparam int H  = HZ * MS / 1000;  // 40 hold cycles

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       warm_rst = 1'b0;
  logic       btn_n = 1'b1;
  logic [2:0] pstate = 3'd0;
  logic       sci_en = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic btn_sts, ovr_sts, btn_en, sci_req, smi_req, wake_req, go_s5;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwrbtn_ctl #(.CLK_HZ(HZ), .HOLD_MS(MS)) u_dut (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .btn_n(btn_n),
    .pstate(pstate), .sci_en(sci_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .btn_sts(btn_sts), .ovr_sts(ovr_sts), .btn_en(btn_en),
    .sci_req(sci_req), .smi_req(smi_req), .wake_req(wake_req), .go_s5(go_s5)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic a, input logic [1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Driver: press and, when a pulse is due, queue its expected cycle.
  task automatic press(input bit expect_pulse);
    @(negedge clk); btn_n = 1'b0;
    if (expect_pulse) exp_q.push_back(cyc + 3 + H);
  endtask

  task automatic release_btn();
    @(negedge clk); btn_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor: every go_s5 pulse must match the head of the queue.
  always @(negedge clk) begin
    if (por_n && go_s5) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8: actual=unexpected go_s5 at cycle %0d expected=none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R7: actual=go_s5 at cycle %0d expected=cycle %0d", cyc, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 btn_sts", btn_sts, 0); chk("R1 ovr_sts", ovr_sts, 0);
    chk("R1 btn_en", btn_en, 0);   chk("R1 go_s5", go_s5, 0);
    chk("R1 sci_req", sci_req, 0); chk("R1 smi_req", smi_req, 0);
    chk("R1 wake_req", wake_req, 0);

    // R2 press with enable off
    press(0);
    repeat (2) @(negedge clk);
    chk("R2 not yet set", btn_sts, 0);
    @(negedge clk);
    chk("R2 set on press", btn_sts, 1);
    chk("R5 no request when disabled", sci_req, 0);

    // R3 clear while held, no re-set
    wr(1'b0, 2'b01);
    chk("R3 cleared while held", btn_sts, 0);
    repeat (10) @(negedge clk);
    chk("R3 stays clear while held", btn_sts, 0);
    release_btn();
    press(0);
    repeat (3) @(negedge clk);
    chk("R3 sets on new press", btn_sts, 1);

    // R4 writing zero has no effect
    wr(1'b0, 2'b00);
    chk("R4 zero write keeps btn_sts", btn_sts, 1);
    release_btn();
    chk("R4 ovr untouched", ovr_sts, 0);
    wr(1'b1, 2'b01);
    chk("R4 enable loaded", btn_en, 1);

    // R5 run-state routing
    pstate = 3'd0; sci_en = 1'b1; #1;
    chk("R5 sci_req", sci_req, 1); chk("R5 smi_req off", smi_req, 0);
    chk("R5 wake off", wake_req, 0);
    sci_en = 1'b0; #1;
    chk("R5 smi_req", smi_req, 1); chk("R5 sci_req off", sci_req, 0);
    // R6 sleep routing
    for (int s = 1; s <= 5; s++) begin
      pstate = 3'(s); #1;
      chk("R6 wake_req in sleep", wake_req, 1);
      chk("R6 no smi in sleep", smi_req, 0);
    end
    pstate = 3'd6; #1;
    chk("R6 reserved state no wake", wake_req, 0);
    pstate = 3'd0; sci_en = 1'b1;

    // R9 warm reset
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    chk("R9 btn_en dropped", btn_en, 0);
    chk("R9 btn_sts kept", btn_sts, 1);
    chk("R9 sci_req off", sci_req, 0);
    wr(1'b0, 2'b01);
    chk("R4 clear by one", btn_sts, 0);

    // R7 hold override
    press(1);
    repeat (H + 8) @(negedge clk);
    chk("R7 ovr_sts set", ovr_sts, 1);
    chk("R7 btn_sts cleared", btn_sts, 0);
    chk("R7 btn_en set", btn_en, 1);
    // R8 keep holding: no second pulse
    repeat (2 * H) @(negedge clk);
    release_btn();

    // R9 override status survives warm reset
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    chk("R9 ovr_sts kept", ovr_sts, 1);
    wr(1'b0, 2'b10);
    chk("R4 ovr cleared", ovr_sts, 0);

    // R8 short press restarts the count, then a full hold pulses again
    press(0);
    repeat (H - 10) @(negedge clk);
    release_btn();
    chk("R8 short press no override", ovr_sts, 0);
    press(1);
    repeat (H + 8) @(negedge clk);
    chk("R8 second hold overrides", ovr_sts, 1);
    release_btn();

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8: actual=%0d pulses missing expected=0", exp_q.size());
    end
    report();
  end
endmodule